// File: doc/BRIEF.md
# Clear Channel Assessment Controller

This block turns three receiver status indications into the channel-busy flag that a CSMA medium access controller consults before it transmits. The indications are a per-cycle energy-detect comparison, the AGC lock state, and a signal-quality verdict with a valid strobe. It keeps a carrier-sense latch that is set whenever the AGC loses lock. It times a 10 µs dwell from a microsecond tick and accepts a quality verdict only inside the 8–9 µs slot of a dwell in which the AGC stayed locked. From these it decides when the receiver has locked onto a signal and enters tracking.

A 3-bit mode selects which of energy detect, carrier sense and signal quality drive the busy flag. One mode ignores the channel and always reports clear. A `cca_valid` flag marks when the busy flag can be trusted. It is low from receive enable until the first quality verdict has been taken, and low again as soon as receive enable drops. All pins are plain control and status levels and strobes. No data flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `cca_ctrl`

## Requirements
- R1: While `rx_en` is low, `busy` and `cca_valid` are 0. The first clock edge that samples `rx_en` low clears tracking, the carrier-sense latch, the quality flag, the pass count and the dwell counter. After reset all outputs are 0.
- R2: The dwell counter starts at 0 when `rx_en` rises. It advances by one on each cycle with `us_tick` high and wraps from 9 back to 0, so one dwell is ten ticks.
- R3: A quality verdict is evaluated only when all of the following hold: `sq_valid` is high while the dwell count equals 8; `agc_lock` is high in that cycle; `agc_lock` has stayed high since the dwell began; no verdict has yet been taken in that dwell. A strobe that fails any of these is ignored.
- R4: A cycle with `rx_en` high and `agc_lock` low sets the carrier-sense latch at the next edge. Whatever the dwell position, this makes `busy` 1 in mode 2.
- R5: A failing verdict (`sq_pass` = 0) clears the carrier-sense latch, the quality flag and the pass count.
- R6: A passing verdict taken while the carrier-sense latch is set enters tracking at the next edge.
- R7: A passing verdict without the carrier-sense latch sets the quality flag. Two consecutive passing verdicts enter tracking, and a failing verdict between them restarts the count.
- R8: Tracking stays set until `rx_en` falls, and verdicts taken while tracking change no state.
- R9: `cca_valid` rises at the edge after the first evaluated verdict following `rx_en` rising and stays high until `rx_en` falls. Tracking never holds with `rx_en` high and `cca_valid` low.
- R10: With `rx_en` high, `busy` follows `cca_mode` as listed here. E is the registered energy detect. C is the carrier-sense latch OR tracking. Q is the quality flag OR tracking. The codes are: 1 = E, 2 = C, 3 = Q, 4 = E|C, 5 = E|Q, 6 = C|Q, 7 = E&(C|Q).
- R11: `cca_mode` = 0 holds `busy` at 0 regardless of every input.
- R12: `ed_hit` is registered once, so a change on it reaches `busy` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable; low clears all state |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| agc_lock | input | 1 | AGC locked level |
| sq_valid | input | 1 | Quality verdict strobe |
| sq_pass | input | 1 | Quality verdict, 1 = pass, read with `sq_valid` |
| ed_hit | input | 1 | Energy-detect comparison result |
| cca_mode | input | 3 | Busy source selection, encoding in R10/R11 |
| busy | output | 1 | Channel busy indication |
| tracking | output | 1 | Receiver has entered tracking |
| cca_valid | output | 1 | Busy indication is meaningful |

## Verification
The bench sends strobes one microsecond early and twice inside one window. A design with a loose window or no once-per-dwell guard would raise `cca_valid` or the quality flag too soon. It also relocks the AGC just before the window of a dwell in which lock was lost. A design that checks only the instantaneous lock would then clear carrier sense on a verdict it should ignore. It checks that one pass with carrier sense enters tracking, and that without carrier sense two passes are needed and an interleaved fail restarts the count. A shared or missing pass counter shows up here as early or late tracking. A sweep over all eight modes, both energy-detect levels and four channel states catches any mis-wired busy combination.

// File: rtl/cca_pkg.sv
package cca_pkg;

  typedef enum logic [2:0] {
    MODE_CLEAR     = 3'd0,
    MODE_ED        = 3'd1,
    MODE_CS        = 3'd2,
    MODE_SQ        = 3'd3,
    MODE_ED_OR_CS  = 3'd4,
    MODE_ED_OR_SQ  = 3'd5,
    MODE_CS_OR_SQ  = 3'd6,
    MODE_ED_AND_RX = 3'd7
  } cca_mode_e;

  typedef struct packed {
    logic ed;
    logic cs;
    logic sq;
  } busy_terms_t;

endpackage

// File: rtl/cca_dwell_timer.sv
module cca_dwell_timer #(
  parameter int DWELL_US = 10,
  parameter int WIN_US   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic us_tick,
  input  logic agc_lock,
  input  logic sq_valid,
  output logic eval
);

  localparam int CW = (DWELL_US > 1) ? $clog2(DWELL_US) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(DWELL_US - 1);
  localparam logic [CW-1:0] WIN_CNT  = CW'(WIN_US);

  logic [CW-1:0] cnt_q;
  logic          lock_ok_q;
  logic          taken_q;
  logic          wrap;
  logic          in_win;

  assign wrap   = us_tick && (cnt_q == LAST_CNT);
  assign in_win = (cnt_q == WIN_CNT);
  assign eval   = rx_en && sq_valid && in_win && lock_ok_q && agc_lock && !taken_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en) begin
      cnt_q     <= '0;
      lock_ok_q <= 1'b1;
      taken_q   <= 1'b0;
    end else begin
      if (us_tick) begin
        cnt_q <= wrap ? '0 : cnt_q + CW'(1);
      end
      if (!agc_lock) begin
        lock_ok_q <= 1'b0;
      end else if (wrap) begin
        lock_ok_q <= 1'b1;
      end
      if (wrap) begin
        taken_q <= 1'b0;
      end else if (eval) begin
        taken_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cca_cs_tracker.sv
module cca_cs_tracker #(
  parameter int PASSES_NO_CS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic agc_lock,
  input  logic eval,
  input  logic sq_pass,
  output logic cs_q,
  output logic sq_q,
  output logic trk_q,
  output logic valid_q
);

  localparam int PW = $clog2(PASSES_NO_CS + 1);
  localparam logic [PW-1:0] LAST_PASS = PW'(PASSES_NO_CS - 1);

  logic [PW-1:0] pass_cnt_q;
  logic          take;

  assign take = eval && !trk_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en) begin
      cs_q       <= 1'b0;
      sq_q       <= 1'b0;
      trk_q      <= 1'b0;
      valid_q    <= 1'b0;
      pass_cnt_q <= '0;
    end else begin
      if (!agc_lock) begin
        cs_q <= 1'b1;
      end
      if (take) begin
        valid_q <= 1'b1;
        if (sq_pass) begin
          sq_q <= 1'b1;
          if (cs_q || (pass_cnt_q == LAST_PASS)) begin
            trk_q <= 1'b1;
          end else begin
            pass_cnt_q <= pass_cnt_q + PW'(1);
          end
        end else begin
          sq_q       <= 1'b0;
          cs_q       <= 1'b0;
          pass_cnt_q <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/cca_busy_mux.sv
module cca_busy_mux
  import cca_pkg::*;
(
  input  logic        rx_en,
  input  logic [2:0]  mode,
  input  busy_terms_t terms,
  output logic        busy
);

  logic pick;

  always_comb begin
    unique case (cca_mode_e'(mode))
      MODE_CLEAR:     pick = 1'b0;
      MODE_ED:        pick = terms.ed;
      MODE_CS:        pick = terms.cs;
      MODE_SQ:        pick = terms.sq;
      MODE_ED_OR_CS:  pick = terms.ed | terms.cs;
      MODE_ED_OR_SQ:  pick = terms.ed | terms.sq;
      MODE_CS_OR_SQ:  pick = terms.cs | terms.sq;
      MODE_ED_AND_RX: pick = terms.ed & (terms.cs | terms.sq);
      default:        pick = 1'b0;
    endcase
  end

  assign busy = rx_en && pick;

endmodule

// File: rtl/cca_ctrl.sv
module cca_ctrl
  import cca_pkg::*;
#(
  parameter int DWELL_US     = 10,
  parameter int WIN_US       = 8,
  parameter int PASSES_NO_CS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       us_tick,
  input  logic       agc_lock,
  input  logic       sq_valid,
  input  logic       sq_pass,
  input  logic       ed_hit,
  input  logic [2:0] cca_mode,
  output logic       busy,
  output logic       tracking,
  output logic       cca_valid
);

  logic        eval;
  logic        cs_q;
  logic        sq_q;
  logic        trk_q;
  logic        valid_q;
  logic        ed_q;
  busy_terms_t terms;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ed_q <= 1'b0;
    end else begin
      ed_q <= rx_en && ed_hit;
    end
  end

  cca_dwell_timer #(
    .DWELL_US(DWELL_US),
    .WIN_US  (WIN_US)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_en   (rx_en),
    .us_tick (us_tick),
    .agc_lock(agc_lock),
    .sq_valid(sq_valid),
    .eval    (eval)
  );

  cca_cs_tracker #(
    .PASSES_NO_CS(PASSES_NO_CS)
  ) u_tracker (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_en   (rx_en),
    .agc_lock(agc_lock),
    .eval    (eval),
    .sq_pass (sq_pass),
    .cs_q    (cs_q),
    .sq_q    (sq_q),
    .trk_q   (trk_q),
    .valid_q (valid_q)
  );

  assign terms.ed = ed_q;
  assign terms.cs = cs_q | trk_q;
  assign terms.sq = sq_q | trk_q;

  cca_busy_mux u_mux (
    .rx_en(rx_en),
    .mode (cca_mode),
    .terms(terms),
    .busy (busy)
  );

  assign tracking  = trk_q;
  assign cca_valid = valid_q && rx_en;

endmodule

// File: rtl/cca_ctrl_chk.sv
module cca_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       agc_lock,
  input logic [2:0] cca_mode,
  input logic       busy,
  input logic       tracking,
  input logic       cca_valid,
  input logic       cs_q
);

  // R1
  clear_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !tracking && !cs_q);

  // R4
  unlock_sets_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !agc_lock) |=> (cs_q || !rx_en));

  // R8
  tracking_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tracking && rx_en) |=> tracking);

  // R9
  valid_with_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tracking && rx_en) |-> cca_valid);

  // R11
  clear_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cca_mode == 3'd0) |-> !busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> (!busy && !cca_valid));

endmodule

bind cca_ctrl cca_ctrl_chk i_cca_ctrl_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_en    (rx_en),
  .agc_lock (agc_lock),
  .cca_mode (cca_mode),
  .busy     (busy),
  .tracking (tracking),
  .cca_valid(cca_valid),
  .cs_q     (cs_q)
);

// File: tb/test_cca_ctrl.sv
module test_cca_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_en;
  logic       us_tick;
  logic       agc_lock;
  logic       sq_valid;
  logic       sq_pass;
  logic       ed_hit;
  logic [2:0] cca_mode;
  logic       busy;
  logic       tracking;
  logic       cca_valid;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  cca_ctrl i_cca_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .us_tick  (us_tick),
    .agc_lock (agc_lock),
    .sq_valid (sq_valid),
    .sq_pass  (sq_pass),
    .ed_hit   (ed_hit),
    .cca_mode (cca_mode),
    .busy     (busy),
    .tracking (tracking),
    .cca_valid(cca_valid)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic sv, input logic sp);
    @(negedge clk);
    us_tick  = t;
    sq_valid = sv;
    sq_pass  = sp;
    @(posedge clk);
    #1;
    us_tick  = 1'b0;
    sq_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0);
  endtask

  task automatic strobe(input logic p);
    cyc(1'b0, 1'b1, p);
  endtask

  task automatic dwell_eval(input logic p);
    ticks(8);
    strobe(p);
    ticks(2);
  endtask

  task automatic restart();
    @(negedge clk);
    rx_en = 1'b0;
    #0.5;
    chk("R1 valid drops with rx_en", cca_valid, 1'b0);
    @(posedge clk);
    #1;
    chk("R1 tracking cleared", tracking, 1'b0);
    @(negedge clk);
    rx_en = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic unlock_pulse();
    @(negedge clk);
    agc_lock = 1'b0;
    @(posedge clk);
    #1;
    @(negedge clk);
    agc_lock = 1'b1;
    @(posedge clk);
    #1;
  endtask

  function automatic logic ref_busy(input int m, input logic e, input logic c, input logic q);
    case (m)
      1: return e;
      2: return c;
      3: return q;
      4: return e | c;
      5: return e | q;
      6: return c | q;
      7: return e & (c | q);
      default: return 1'b0;
    endcase
  endfunction

  task automatic sweep(input string tag, input logic c, input logic q);
    for (int m = 0; m < 8; m++) begin
      for (int e = 0; e < 2; e++) begin
        @(negedge clk);
        cca_mode = 3'(m);
        ed_hit   = e[0];
        @(posedge clk);
        #1;
        if (m == 0) chk({"R11 clear mode ", tag}, busy, 1'b0);
        else        chk({"R10 mode sweep ", tag}, busy, ref_busy(m, e[0], c, q));
      end
    end
    @(negedge clk);
    ed_hit = 1'b0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL R1 watchdog: done=0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; us_tick = 1'b0; agc_lock = 1'b1;
    sq_valid = 1'b0; sq_pass = 1'b0; ed_hit = 1'b0; cca_mode = 3'd6;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset busy", busy, 1'b0);
    chk("R1 reset tracking", tracking, 1'b0);
    chk("R1 reset valid", cca_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    rx_en = 1'b1;
    @(posedge clk);
    #1;

    // R3: strobe one tick early is ignored
    ticks(7);
    strobe(1'b1);
    chk("R3 early strobe ignored", cca_valid, 1'b0);
    ticks(1);
    strobe(1'b0);
    chk("R9 valid after first verdict", cca_valid, 1'b1);
    chk("R5 fail leaves quality clear", busy, 1'b0);
    strobe(1'b1);
    chk("R3 second strobe in window ignored", busy, 1'b0);
    ticks(2);

    // R7: two passes, fail in between restarts
    dwell_eval(1'b1);
    chk("R7 one pass sets quality", busy, 1'b1);
    chk("R7 one pass no tracking", tracking, 1'b0);
    dwell_eval(1'b0);
    chk("R5 fail clears quality", busy, 1'b0);
    dwell_eval(1'b1);
    chk("R7 pass after fail no tracking", tracking, 1'b0);
    dwell_eval(1'b1);
    chk("R7 two consecutive passes track", tracking, 1'b1);
    dwell_eval(1'b0);
    chk("R8 fail while tracking ignored", tracking, 1'b1);
    chk("R8 busy held while tracking", busy, 1'b1);
    restart();
    chk("R1 busy after restart", busy, 1'b0);

    // R2: a strobe after 18 ticks lands in the second window
    ticks(18);
    strobe(1'b0);
    chk("R2 dwell wraps after ten ticks", cca_valid, 1'b1);
    ticks(2);

    // R4/R5: carrier sense path
    cca_mode = 3'd2;
    restart();
    ticks(3);
    unlock_pulse();
    chk("R4 unlock sets carrier sense", busy, 1'b1);
    ticks(5);
    strobe(1'b0);
    chk("R3 strobe in unlocked dwell ignored", cca_valid, 1'b0);
    chk("R3 carrier sense kept", busy, 1'b1);
    ticks(2);
    ticks(8);
    strobe(1'b0);
    chk("R5 fail clears carrier sense", busy, 1'b0);
    chk("R9 valid after fail", cca_valid, 1'b1);
    ticks(2);

    // R6: carrier sense plus one pass tracks
    ticks(2);
    unlock_pulse();
    ticks(8);
    ticks(8);
    strobe(1'b1);
    chk("R6 pass with carrier sense tracks", tracking, 1'b1);
    ticks(2);

    // R12: energy detect latency
    cca_mode = 3'd1;
    restart();
    @(negedge clk);
    ed_hit = 1'b1;
    #1;
    chk("R12 busy not yet from ed", busy, 1'b0);
    @(posedge clk);
    #1;
    chk("R12 busy one edge after ed", busy, 1'b1);
    @(negedge clk);
    ed_hit = 1'b0;
    @(posedge clk);
    #1;

    // R10/R11 sweeps over four channel states
    restart();
    sweep("idle", 1'b0, 1'b0);
    dwell_eval(1'b1);
    sweep("quality", 1'b0, 1'b1);
    restart();
    unlock_pulse();
    sweep("carrier", 1'b1, 1'b0);
    ticks(10);
    ticks(8);
    strobe(1'b1);
    sweep("tracking", 1'b1, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule